// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block looks after an asynchronous DRAM's start-up and its periodic refresh. After reset it stays silent for a programmable power-up pause. It then runs eight dummy refresh cycles back to back, and only after the last of them does it tell the rest of the system that normal accesses may begin. From then on it owes one refresh per interval. The interval is chosen so that the whole row space is covered within the retention time, which is roughly one refresh every 15.6 µs.

The block does not own the strobe bus. It raises a request to the access controller and starts a refresh cycle only after the controller grants the bus. Refreshes that fall due while the grant is withheld are kept as a small backlog of at most eight. A full backlog raises an urgent flag, and the arbiter must serve that flag before anything else.

A parameter selects one of two refresh waveforms:
- **Counter refresh:** the column strobe falls before the row strobe, so the device uses its own internal row counter and the address lines carry zero.
- **Row-only refresh:** the column strobe stays high, and the block drives its own row counter onto the address lines.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, rasN and casN are high, busReq, initDone and urgent are low.
- R2: busReq stays low for the first PAUSE_CYC clock cycles after reset is released and is high in cycle PAUSE_CYC.
- R3: After the pause exactly INIT_REFRESHES (8) refresh cycles run back to back, separated by RP_CYC+SETUP_CYC+1 cycles of rasN high; initDone rises in the cycle the eighth cycle's precharge ends and never falls again.
- R4: A refresh cycle begins only in the clock cycle after busGrant was sampled high, and no strobe moves while the grant is withheld.
- R5: In counter-refresh mode (RAS_ONLY=0) casN falls exactly SETUP_CYC cycles before rasN falls, rasN stays low RAS_CYC cycles, casN returns high CHR_CYC cycles after rasN falls (CHR_CYC < RAS_CYC), and rowAddr reads 0.
- R6: In row-only mode (RAS_ONLY=1) casN never goes low, rowAddr shows the row SETUP_CYC cycles before rasN falls and holds it unchanged while rasN is low for RAS_CYC cycles.
- R7: Between any two refresh cycles rasN stays high for at least RP_CYC cycles.
- R8: Once initDone is high, one refresh falls due every INTERVAL_CYC cycles (the first INTERVAL_CYC cycles after initDone rises); whenever busReq is low, the number of refreshes completed after init equals the number of intervals elapsed.
- R9: Refreshes that fall due without a grant are held as a backlog of up to MAX_PENDING (8), and any that fall due beyond that are dropped. urgent is high exactly while the backlog is full, and it clears when a backlog refresh is launched.
- R10: The row counter starts at 0 and steps by one per completed refresh cycle, including the init cycles. It wraps from 2^ROW_BITS-1 (1023) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Strobe bus granted by the access controller |
| busReq | output | 1 | Strobe bus wanted (init, backlog or cycle in flight) |
| urgent | output | 1 | Refresh backlog full, serve first |
| initDone | output | 1 | Power-up sequence complete, normal access allowed |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| rowAddr | output | ROW_BITS | Row address during row-only refresh, otherwise 0 |

## Verification
Two events can land in the same clock edge. One is the interval tick that adds a refresh to the backlog. The other is the launch of a refresh, which takes one out of the backlog. The row-only instance is given a short interval and a grant latency drawn at random, so ticks fall on every phase of the refresh cycle, including the launch edge. The result is judged by conservation: each time the request drops, the refreshes completed since init must match the elapsed intervals exactly. The counter-refresh instance drives the backlog into saturation and keeps the grant off for two further intervals. It then checks that urgent rises on the eighth interval and that releasing the grant produces exactly eight refresh cycles.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_PRE    = 2'd3
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic startWork;
    logic finishWork;
    logic loadLead;
    logic loadActive;
    logic loadPre;
    logic rowDrive;
  } ctrl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic haveWork;
    logic timerZero;
    logic casWindow;
  } dp_status_t;

endpackage

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int PAUSE_CYC      = 20000,
  parameter int INTERVAL_CYC   = 1560,
  parameter int INIT_REFRESHES = 8,
  parameter int MAX_PENDING    = 8,
  parameter int ROW_BITS       = 10,
  parameter int SETUP_CYC      = 2,
  parameter int RAS_CYC        = 5,
  parameter int CHR_CYC        = 2,
  parameter int RP_CYC         = 3,
  parameter bit RAS_ONLY       = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  output dp_status_t          status,
  output logic                initDone,
  output logic                urgent,
  output logic [ROW_BITS-1:0] rowAddr
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int INT_W   = $clog2(INTERVAL_CYC + 1);
  localparam int PEND_W  = $clog2(MAX_PENDING + 1);
  localparam int INIT_W  = $clog2(INIT_REFRESHES + 1);
  localparam int TMAX_A  = (SETUP_CYC > RAS_CYC) ? SETUP_CYC : RAS_CYC;
  localparam int TMAX    = (TMAX_A > RP_CYC) ? TMAX_A : RP_CYC;
  localparam int TIMER_W = $clog2(TMAX + 1);

  logic [PAUSE_W-1:0]  pauseCnt;
  logic                pauseDone;
  logic [INIT_W-1:0]   initCnt;
  logic                initDoneQ;
  logic [INT_W-1:0]    intervalCnt;
  logic                tick;
  logic [PEND_W-1:0]   pendCnt;
  logic                pendFull;
  logic                pendInc;
  logic                pendDec;
  logic [ROW_BITS-1:0] rowCnt;
  logic [TIMER_W-1:0]  phaseTimer;

  // power-up pause
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseCnt  <= '0;
      pauseDone <= 1'b0;
    end else if (!pauseDone) begin
      if (pauseCnt == PAUSE_W'(PAUSE_CYC - 1)) pauseDone <= 1'b1;
      else                                     pauseCnt  <= pauseCnt + 1'b1;
    end
  end

  // init refresh count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCnt   <= '0;
      initDoneQ <= 1'b0;
    end else if (strobe.finishWork && !initDoneQ) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == INIT_W'(INIT_REFRESHES - 1)) initDoneQ <= 1'b1;
    end
  end

  // refresh interval ticker
  assign tick = initDoneQ && (intervalCnt == INT_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN)          intervalCnt <= '0;
    else if (initDoneQ) intervalCnt <= tick ? '0 : intervalCnt + 1'b1;
  end

  // backlog of owed refreshes, saturating
  assign pendFull = (pendCnt == PEND_W'(MAX_PENDING));
  assign pendDec  = strobe.startWork && initDoneQ;
  assign pendInc  = tick && (!pendFull || pendDec);

  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= '0;
    else begin
      unique case ({pendInc, pendDec})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // row counter for row-only refresh
  always_ff @(posedge clk) begin
    if (!rstN)                 rowCnt <= '0;
    else if (strobe.finishWork) rowCnt <= rowCnt + 1'b1;
  end

  // shared phase timer
  always_ff @(posedge clk) begin
    if (!rstN)                  phaseTimer <= '0;
    else if (strobe.loadLead)   phaseTimer <= TIMER_W'(SETUP_CYC - 1);
    else if (strobe.loadActive) phaseTimer <= TIMER_W'(RAS_CYC - 1);
    else if (strobe.loadPre)    phaseTimer <= TIMER_W'(RP_CYC - 1);
    else if (phaseTimer != '0)  phaseTimer <= phaseTimer - 1'b1;
  end

  assign status.haveWork  = initDoneQ ? (pendCnt != '0) : pauseDone;
  assign status.timerZero = (phaseTimer == '0);
  assign status.casWindow = (phaseTimer >= TIMER_W'(RAS_CYC - CHR_CYC));

  assign initDone = initDoneQ;
  assign urgent   = pendFull;
  assign rowAddr  = ((RAS_ONLY != 1'b0) && strobe.rowDrive) ? rowCnt : '0;

  AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_W'(MAX_PENDING)); // R9
  AST_URGENT_AFTER_INIT: assert property (@(posedge clk) disable iff (!rstN)
    urgent |-> initDoneQ); // R9
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDoneQ |=> initDoneQ); // R3
  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !pauseDone |-> !strobe.startWork); // R2
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rowDrive && $past(strobe.rowDrive)) |-> $stable(rowCnt)); // R6

endmodule

// File: rtl/refresh_sched_ctl.sv
module refresh_sched_ctl
  import refresh_sched_pkg::*;
#(
  parameter bit RAS_ONLY = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busGrant,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         busReq,
  output logic         rasLow,
  output logic         casLow
);

  phase_e stateQ;
  phase_e stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      PH_IDLE: begin
        if (status.haveWork && busGrant) begin
          stateD           = PH_LEAD;
          strobe.startWork = 1'b1;
          strobe.loadLead  = 1'b1;
        end
      end
      PH_LEAD: begin
        if (status.timerZero) begin
          stateD            = PH_ACTIVE;
          strobe.loadActive = 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (status.timerZero) begin
          stateD         = PH_PRE;
          strobe.loadPre = 1'b1;
        end
      end
      PH_PRE: begin
        if (status.timerZero) begin
          stateD            = PH_IDLE;
          strobe.finishWork = 1'b1;
        end
      end
      default: stateD = PH_IDLE;
    endcase
    strobe.rowDrive = (stateQ == PH_LEAD) || (stateQ == PH_ACTIVE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= PH_IDLE;
    else       stateQ <= stateD;
  end

  assign busReq = status.haveWork || (stateQ != PH_IDLE);
  assign rasLow = (stateQ == PH_ACTIVE);
  assign casLow = (RAS_ONLY == 1'b0) &&
                  ((stateQ == PH_LEAD) || ((stateQ == PH_ACTIVE) && status.casWindow));

  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == PH_LEAD) && ($past(stateQ) == PH_IDLE)) |-> $past(busGrant)); // R4
  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rstN)
    ((RAS_ONLY == 1'b0) && rasLow && !$past(rasLow)) |-> (casLow && $past(casLow))); // R5

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int PAUSE_CYC      = 20000,
  parameter int INTERVAL_CYC   = 1560,
  parameter int INIT_REFRESHES = 8,
  parameter int MAX_PENDING    = 8,
  parameter int ROW_BITS       = 10,
  parameter int SETUP_CYC      = 2,
  parameter int RAS_CYC        = 5,
  parameter int CHR_CYC        = 2,
  parameter int RP_CYC         = 3,
  parameter bit RAS_ONLY       = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busGrant,
  output logic                busReq,
  output logic                urgent,
  output logic                initDone,
  output logic                rasN,
  output logic                casN,
  output logic [ROW_BITS-1:0] rowAddr
);

  ctrl_strobe_t strobe;
  dp_status_t   status;
  logic         rasLow;
  logic         casLow;

  refresh_sched_ctl #(
    .RAS_ONLY(RAS_ONLY)
  ) uCtl (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .status(status),
    .strobe(strobe), .busReq(busReq), .rasLow(rasLow), .casLow(casLow)
  );

  refresh_sched_dp #(
    .PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC),
    .INIT_REFRESHES(INIT_REFRESHES), .MAX_PENDING(MAX_PENDING),
    .ROW_BITS(ROW_BITS), .SETUP_CYC(SETUP_CYC), .RAS_CYC(RAS_CYC),
    .CHR_CYC(CHR_CYC), .RP_CYC(RP_CYC), .RAS_ONLY(RAS_ONLY)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .initDone(initDone), .urgent(urgent), .rowAddr(rowAddr)
  );

  assign rasN = ~rasLow;
  assign casN = ~casLow;

endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  // instance u0: row-only refresh, short interval
  localparam int PAUSE0 = 40, INT0 = 24, SETUP0 = 2, RAS0 = 4, CHR0 = 2, RP0 = 3;
  // instance u1: counter refresh, long interval
  localparam int PAUSE1 = 100, INT1 = 300, SETUP1 = 2, RAS1 = 5, CHR1 = 3, RP1 = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grant0 = 1'b0, grant1 = 1'b0;
  logic req0, urg0, init0, ras0, cas0;
  logic req1, urg1, init1, ras1, cas1;
  logic [9:0] addr0, addr1;
  int cyc = 0;
  int total = 0, bad = 0;
  bit done0 = 1'b0, done1 = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  refresh_sched #(.PAUSE_CYC(PAUSE0), .INTERVAL_CYC(INT0), .ROW_BITS(10),
    .SETUP_CYC(SETUP0), .RAS_CYC(RAS0), .CHR_CYC(CHR0), .RP_CYC(RP0), .RAS_ONLY(1'b1))
  u0 (.clk(clk), .rstN(rstN), .busGrant(grant0), .busReq(req0), .urgent(urg0),
      .initDone(init0), .rasN(ras0), .casN(cas0), .rowAddr(addr0));

  refresh_sched #(.PAUSE_CYC(PAUSE1), .INTERVAL_CYC(INT1), .ROW_BITS(10),
    .SETUP_CYC(SETUP1), .RAS_CYC(RAS1), .CHR_CYC(CHR1), .RP_CYC(RP1), .RAS_ONLY(1'b0))
  u1 (.clk(clk), .rstN(rstN), .busGrant(grant1), .busReq(req1), .urgent(urg1),
      .initDone(init1), .rasN(ras1), .casN(cas1), .rowAddr(addr1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextRow(input int r);
    return (r + 1) % 1024;
  endfunction

  function automatic int expTicks(input int elapsed, input int interval);
    return elapsed / interval;
  endfunction

  // u0: row-only refresh, random grant latency
  initial begin
    bit prevRas = 1'b1;
    int prevAddr = 0, lowCnt = 0, highCnt = 0, refCnt = 0, expRow = 0;
    int p0 = 0, waitCnt = 0;
    bit initSeen = 1'b0, addrBad = 1'b0, casSeen = 1'b0;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (cyc < PAUSE0) check(!req0, "R2 u0 early request", req0, 0);
      if (cyc == PAUSE0) check(req0, "R2 u0 request after pause", req0, 1);
      if (!cas0) casSeen = 1'b1;
      if (prevRas && !ras0) begin
        check(grant0, "R4 u0 ras fall without grant", grant0, 1);
        check(addr0 == expRow, "R10 u0 row at ras fall", addr0, expRow);
        check(prevAddr == expRow, "R6 u0 row setup", prevAddr, expRow);
        if (refCnt > 0 && refCnt < 8)
          check(highCnt == RP0 + 1 + SETUP0, "R3 u0 init gap", highCnt, RP0 + 1 + SETUP0);
        else if (refCnt >= 8)
          check(highCnt >= RP0, "R7 u0 precharge", highCnt, RP0);
        lowCnt = 1;
        addrBad = 1'b0;
      end else if (!ras0) begin
        lowCnt++;
        if (addr0 != expRow) addrBad = 1'b1;
      end else if (!prevRas && ras0) begin
        check(lowCnt == RAS0, "R6 u0 ras width", lowCnt, RAS0);
        check(!addrBad && !casSeen, "R6 u0 row hold / cas high", {addrBad, casSeen}, 0);
        refCnt++;
        expRow = nextRow(expRow);
        highCnt = 1;
      end else highCnt++;
      if (init0 && !initSeen) begin
        initSeen = 1'b1;
        p0 = cyc;
        check(refCnt == 8, "R3 u0 initDone after eighth", refCnt, 8);
      end
      if (initSeen && !init0) check(1'b0, "R3 u0 initDone fell", 0, 1);
      if (refCnt >= 1040 && !req0) begin
        check(refCnt - 8 == expTicks(cyc - p0, INT0), "R8 u0 refresh count",
              refCnt - 8, expTicks(cyc - p0, INT0));
        done0 = 1'b1;
        grant0 = 1'b0;
        break;
      end
      prevRas = ras0;
      prevAddr = addr0;
      if (!req0) begin
        grant0 = 1'b0;
        waitCnt = $urandom_range(5, 0);
      end else if (!grant0) begin
        if (waitCnt == 0) grant0 = 1'b1;
        else waitCnt--;
      end
    end
  end

  // u1: counter refresh, backlog saturation
  initial begin
    bit prevRas = 1'b1, prevCas = 1'b1;
    int leadCnt = 0, lowCnt = 0, chrCnt = 0, refCnt = 0, p1 = 0;
    bit initSeen = 1'b0, hold1 = 1'b0, released = 1'b0, firstAfter = 1'b0, addrNz = 1'b0;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (cyc < PAUSE1) check(!req1, "R2 u1 early request", req1, 0);
      if (addr1 != 0) addrNz = 1'b1;
      if (prevCas && !cas1 && ras1) begin
        check(grant1, "R4 u1 cas fall without grant", grant1, 1);
        check(!hold1, "R4 u1 cycle while grant held off", hold1, 0);
        if (firstAfter) begin
          check(!urg1, "R9 u1 urgent clears on launch", urg1, 0);
          firstAfter = 1'b0;
        end
        leadCnt = 1;
      end else if (!cas1 && ras1) leadCnt++;
      if (prevRas && !ras1) begin
        check(!cas1 && leadCnt == SETUP1, "R5 u1 cas lead", leadCnt, SETUP1);
        lowCnt = 1;
        chrCnt = cas1 ? 0 : 1;
      end else if (!ras1) begin
        lowCnt++;
        if (!cas1) chrCnt++;
      end else if (!prevRas && ras1) begin
        check(lowCnt == RAS1, "R5 u1 ras width", lowCnt, RAS1);
        check(chrCnt == CHR1, "R5 u1 cas hold after ras", chrCnt, CHR1);
        check(!addrNz, "R5 u1 address zero", addrNz, 0);
        refCnt++;
      end
      if (init1 && !initSeen) begin
        initSeen = 1'b1;
        p1 = cyc;
        hold1 = 1'b1;
        check(refCnt == 8, "R3 u1 initDone after eighth", refCnt, 8);
      end
      if (initSeen) begin
        if (cyc == p1 + 8 * INT1 - 1) check(!urg1, "R9 u1 urgent early", urg1, 0);
        if (cyc == p1 + 8 * INT1) check(urg1, "R9 u1 urgent on eighth owed", urg1, 1);
        if (cyc == p1 + 10 * INT1 + 1) begin
          check(urg1, "R9 u1 urgent held at limit", urg1, 1);
          check(refCnt == 8, "R4 u1 no refresh without grant", refCnt, 8);
          hold1 = 1'b0;
          released = 1'b1;
          firstAfter = 1'b1;
        end else if (released && !req1) begin
          check(refCnt - 8 == 8, "R9 u1 backlog serviced", refCnt - 8, 8);
          done1 = 1'b1;
          grant1 = 1'b0;
          break;
        end
      end
      prevRas = ras1;
      prevCas = cas1;
      grant1 = hold1 ? 1'b0 : req1;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ras0 && cas0 && !req0 && !init0 && !urg0, "R1 u0 reset state",
          {ras0, cas0, req0, init0, urg0}, 5'b11000);
    check(ras1 && cas1 && !req1 && !init1 && !urg1, "R1 u1 reset state",
          {ras1, cas1, req1, init1, urg1}, 5'b11000);
    rstN = 1'b1;
    while (!(done0 && done1)) begin
      @(negedge clk);
      if (cyc > WATCHDOG) begin
        check(1'b0, "R8 watchdog expired", cyc, WATCHDOG);
        break;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule